// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block watches a frame clock (one period per audio sample) that arrives from outside, counts how many master-clock cycles fit into each of its periods, and works out which of six supported oversampling ratios the system is running at. The result is a 3-bit ratio code that downstream filter and clock-divider logic uses directly, so no software setting is needed when the converter runs as a clock slave.

The frame clock is asynchronous to the master clock, so it is re-timed by a two-flop synchroniser. Its rising edges bound each measurement window. A count that falls close enough to a supported ratio selects that ratio. Any other count, including a frame clock that has stopped, raises an error flag and leaves the last good code in place. A locked flag reports that the measured ratio has been stable for several frames.

A converter with separate record and playback frame clocks uses one instance per frame clock. Both instances share the master clock, and each may settle on its own ratio.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is high, and on the cycle after it, ratio_code is 7 (no ratio), locked is 0 and ratio_err is 0.
- R2: Frame periods of exactly 128, 192, 256, 384, 512 and 768 master clocks give ratio_code 0, 1, 2, 3, 4 and 5 respectively. Code 6 never appears.
- R3: A period within ±2 master clocks of a supported ratio selects that ratio's code. Examples are 126 to code 0, 258 to code 2, 510 to code 4 and 766 to code 5.
- R4: A period that is more than 2 away from every supported ratio (for example 259) sets ratio_err to 1, clears locked, and leaves ratio_code unchanged.
- R5: locked rises only once three consecutive measured frames have given the same code. It stays 0 after only one or two such frames.
- R6: A measured frame whose code differs from the current code updates ratio_code and clears locked. Any matching frame clears ratio_err.
- R7: When the frame clock shows no rising edge for more than 800 master clocks, ratio_err goes to 1, locked goes to 0 and ratio_code is kept. The first period measured after such a stall also counts as an error.
- R8: The first rising edge after reset only opens a measurement window, so the outputs keep their reset values until a second rising edge ends the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_in | input | 1 | Frame clock, asynchronous to clk |
| ratio_code | output | 3 | Detected ratio: 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 7=none |
| locked | output | 1 | High after three consecutive frames agree on one ratio |
| ratio_err | output | 1 | High after an unrecognised period or a stall, until the next matching frame |

## Verification
The bench builds the detector with its default parameters: a tolerance of 2, a saturation limit of 800 and a lock depth of 3. These settings let it use the exact ratios, periods at both edges of the tolerance window, a period one step outside the window, and a stall long enough to pass the 800-count limit. Scenarios chain different periods without a reset in between. This exercises lock loss on a ratio change, recovery after an error, and recovery after the saturated measurement that follows a stall.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  localparam int unsigned NUM_RATIOS = 6;
  localparam int unsigned CODE_W     = 3;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'd7;

  // master clocks per frame for each ratio code
  function automatic int unsigned ratio_value(input int unsigned idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      default: return 768;
    endcase
  endfunction

endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic meta_q;
  logic sync_q;
  logic hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign rise = sync_q & ~hist_q;

endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int unsigned SAT_LIMIT = 800,
  parameter int unsigned CNT_W     = $clog2(SAT_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_count,
  output logic             stall
);

  localparam logic [CNT_W-1:0] SAT_TOP  = CNT_W'(SAT_LIMIT + 1);
  localparam logic [CNT_W-1:0] SAT_EDGE = CNT_W'(SAT_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      primed_q   <= 1'b0;
      meas_valid <= 1'b0;
      meas_count <= '0;
      stall      <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      stall      <= 1'b0;
      if (rise) begin
        cnt_q    <= CNT_W'(1);
        primed_q <= 1'b1;
        if (primed_q) begin
          meas_valid <= 1'b1;
          meas_count <= cnt_q;
        end
      end else if (cnt_q < SAT_TOP) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == SAT_EDGE) stall <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mrd_ratio_classifier.sv
module mrd_ratio_classifier
  import mrd_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned TOL   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_valid,
  input  logic [CNT_W-1:0]  meas_count,
  input  logic              stall,
  output logic              cls_valid,
  output logic              cls_hit,
  output logic [CODE_W-1:0] cls_code
);

  localparam int unsigned DW = CNT_W + 2;

  logic [NUM_RATIOS-1:0] hit_vec;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam logic [DW-1:0] LO = DW'(ratio_value(i) - TOL);
    localparam logic [DW-1:0] HI = DW'(ratio_value(i) + TOL);
    logic [DW-1:0] wide;
    assign wide       = DW'(meas_count);
    assign hit_vec[i] = (wide >= LO) && (wide <= HI);
  end

  logic [CODE_W-1:0] enc;
  always_comb begin
    enc = CODE_NONE;
    for (int j = NUM_RATIOS - 1; j >= 0; j--) begin
      if (hit_vec[j]) enc = CODE_W'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_valid <= 1'b0;
      cls_hit   <= 1'b0;
      cls_code  <= CODE_NONE;
    end else begin
      cls_valid <= meas_valid | stall;
      cls_hit   <= meas_valid & (|hit_vec);
      cls_code  <= enc;
    end
  end

endmodule

// File: rtl/mrd_lock_tracker.sv
module mrd_lock_tracker
  import mrd_pkg::*;
#(
  parameter int unsigned LOCK_FRAMES = 3,
  parameter int unsigned RUN_W       = $clog2(LOCK_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cls_valid,
  input  logic              cls_hit,
  input  logic [CODE_W-1:0] cls_code,
  output logic [CODE_W-1:0] ratio_code,
  output logic              locked,
  output logic              ratio_err
);

  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_FRAMES);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nx;

  always_comb begin
    if ((cls_code == ratio_code) && (run_q != '0)) begin
      run_nx = (run_q < RUN_MAX) ? run_q + 1'b1 : RUN_MAX;
    end else begin
      run_nx = RUN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= '0;
      ratio_code <= CODE_NONE;
      locked     <= 1'b0;
      ratio_err  <= 1'b0;
    end else if (cls_valid) begin
      if (cls_hit) begin
        ratio_code <= cls_code;
        run_q      <= run_nx;
        locked     <= (run_nx >= RUN_MAX);
        ratio_err  <= 1'b0;
      end else begin
        run_q     <= '0;
        locked    <= 1'b0;
        ratio_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int unsigned TOL         = 2,
  parameter int unsigned SAT_LIMIT   = 800,
  parameter int unsigned LOCK_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_in,
  output logic [CODE_W-1:0] ratio_code,
  output logic              locked,
  output logic              ratio_err
);

  localparam int unsigned CNT_W = $clog2(SAT_LIMIT + 2);
  localparam int unsigned RUN_W = $clog2(LOCK_FRAMES + 1);

  logic              rise;
  logic              meas_valid;
  logic [CNT_W-1:0]  meas_count;
  logic              stall;
  logic              cls_valid;
  logic              cls_hit;
  logic [CODE_W-1:0] cls_code;

  mrd_edge_sync u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (frame_in),
    .rise     (rise)
  );

  mrd_period_counter #(
    .SAT_LIMIT (SAT_LIMIT),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .meas_valid (meas_valid),
    .meas_count (meas_count),
    .stall      (stall)
  );

  mrd_ratio_classifier #(
    .CNT_W (CNT_W),
    .TOL   (TOL)
  ) u_cls (
    .clk        (clk),
    .rst        (rst),
    .meas_valid (meas_valid),
    .meas_count (meas_count),
    .stall      (stall),
    .cls_valid  (cls_valid),
    .cls_hit    (cls_hit),
    .cls_code   (cls_code)
  );

  mrd_lock_tracker #(
    .LOCK_FRAMES (LOCK_FRAMES),
    .RUN_W       (RUN_W)
  ) u_lock (
    .clk        (clk),
    .rst        (rst),
    .cls_valid  (cls_valid),
    .cls_hit    (cls_hit),
    .cls_code   (cls_code),
    .ratio_code (ratio_code),
    .locked     (locked),
    .ratio_err  (ratio_err)
  );

endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int unsigned SAT_LIMIT = 800
) (
  input logic       clk,
  input logic       rst,
  input logic       frame_in,
  input logic [2:0] ratio_code,
  input logic       locked,
  input logic       ratio_err
);

  localparam int unsigned GAP_LIM = SAT_LIMIT + 8;
  localparam int unsigned GW      = $clog2(GAP_LIM + 2);

  logic          prev_in;
  logic [GW-1:0] gap;

  // cycles since the raw frame clock last rose
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_in <= 1'b0;
      gap     <= '0;
    end else begin
      prev_in <= frame_in;
      if (frame_in && !prev_in) gap <= '0;
      else if (gap < GW'(GAP_LIM)) gap <= gap + 1'b1;
    end
  end

  // R1
  p_reset_values_r1: assert property (@(posedge clk)
    rst |=> (ratio_code == 3'd7 && !locked && !ratio_err));

  // R2
  p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
    ratio_code != 3'd6);

  // R4
  p_err_keeps_code_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ratio_err) |-> $stable(ratio_code));

  // R5
  p_lock_same_code_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $stable(ratio_code));

  // R6
  p_lock_no_err_r6: assert property (@(posedge clk) disable iff (rst)
    locked |-> !ratio_err);

  // R7
  p_stall_flagged_r7: assert property (@(posedge clk) disable iff (rst)
    (gap >= GW'(GAP_LIM)) |-> (ratio_err && !locked));

endmodule

bind mclk_ratio_detect mrd_checker #(.SAT_LIMIT(SAT_LIMIT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_in   (frame_in),
  .ratio_code (ratio_code),
  .locked     (locked),
  .ratio_err  (ratio_err)
);

// File: tb/sim_mclk_ratio_detect.sv
`timescale 1ns/1ps
module sim_mclk_ratio_detect;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_in = 1'b0;
  logic [2:0] ratio_code;
  logic       locked;
  logic       ratio_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mclk_ratio_detect u0 (
    .clk        (clk),
    .rst        (rst),
    .frame_in   (frame_in),
    .ratio_code (ratio_code),
    .locked     (locked),
    .ratio_err  (ratio_err)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int code,
                           input int lk, input int er);
    check(req, "ratio_code", int'(ratio_code), code);
    check(req, "locked", int'(locked), lk);
    check(req, "ratio_err", int'(ratio_err), er);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    frame_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // n frames of period p; each frame starts with a rising edge
  task automatic frames(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      frame_in = 1'b1;
      repeat (p / 2) @(negedge clk);
      frame_in = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1", 7, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1", 7, 0, 0);
  endtask

  task automatic t_first_window();
    do_reset();
    frames(256, 1);
    check_all("R8", 7, 0, 0);
  endtask

  task automatic t_exact(input int p, input int code);
    do_reset();
    frames(p, 4);
    check_all("R2", code, 1, 0);
  endtask

  task automatic t_lock_count();
    do_reset();
    frames(384, 2);
    check_all("R5", 3, 0, 0);
    frames(384, 1);
    check_all("R5", 3, 0, 0);
    frames(384, 1);
    check_all("R5", 3, 1, 0);
  endtask

  task automatic t_tolerance();
    do_reset();
    frames(258, 4);
    check_all("R3", 2, 1, 0);
    frames(126, 4);
    check_all("R3", 0, 1, 0);
    do_reset();
    frames(510, 4);
    check_all("R3", 4, 1, 0);
    do_reset();
    frames(766, 4);
    check_all("R3", 5, 1, 0);
  endtask

  task automatic t_bad_period();
    do_reset();
    frames(256, 4);
    frames(259, 2);
    check_all("R4", 2, 0, 1);
    frames(256, 2);
    check_all("R6", 2, 0, 0);
    frames(256, 2);
    check_all("R6", 2, 1, 0);
  endtask

  task automatic t_ratio_change();
    do_reset();
    frames(256, 4);
    frames(512, 2);
    check_all("R6", 4, 0, 0);
    frames(512, 1);
    check_all("R6", 4, 0, 0);
    frames(512, 1);
    check_all("R6", 4, 1, 0);
  endtask

  task automatic t_stall();
    do_reset();
    frames(256, 4);
    frame_in = 1'b1;
    repeat (5) @(negedge clk);
    frame_in = 1'b0;
    repeat (1000) @(negedge clk);
    check_all("R7", 2, 0, 1);
    frames(192, 1);
    check_all("R7", 2, 0, 1);
    frames(192, 3);
    check_all("R7", 1, 1, 0);
  endtask

  initial begin
    t_reset();
    t_first_window();
    t_exact(128, 0);
    t_exact(192, 1);
    t_exact(256, 2);
    t_exact(384, 3);
    t_exact(512, 4);
    t_exact(768, 5);
    t_lock_count();
    t_tolerance();
    t_bad_period();
    t_ratio_change();
    t_stall();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule